// File: doc/BRIEF.md
# Tagged Next-Block Data Prefetcher

This block sits next to a level-one data cache and watches the cache's demand accesses. For each access it receives the byte address, whether the access hit, and the tag bit of the line that was hit. When an access qualifies as a trigger, the block asks for the block that directly follows the accessed one. It also tells the cache which tag value to write for each line fill, and when to clear a tag bit.

A parameter picks one of two trigger policies.

- **Miss-only policy:** a prefetch is requested only when an access misses.
- **Tagged policy:** every line carries one tag bit. A line filled by a demand fetch gets tag 0 and a line filled by a prefetch gets tag 1. Two events trigger a prefetch: a demand miss, and the first reference to a prefetched line. On that first reference the block also tells the cache to clear the line's bit, so the line triggers only once.

Requests leave through a single output register with a valid/ready handshake. A register holding the last issued address suppresses a request that would repeat it.

Top module: `seq_lookahead_pf`

## Requirements
- R1: While reset is asserted and on the first cycle after it, pf_valid, tag_clr and fill_tag_we are all 0.
- R2: A prefetch address is the accessed byte address with its block-offset bits cleared plus BLK_BYTES, taken modulo 2^ADDR_W, so its low log2(BLK_BYTES) bits are always 0 (an access in the top block yields address 0).
- R3: With TAGGED=0, an access that hits never starts a prefetch, whatever its tag bit; tag_clr and fill_tag_we stay 0 in this mode.
- R4: With TAGGED=0 or 1, a valid access with acc_hit=0 is a trigger.
- R5: With TAGGED=1, a valid access with acc_hit=1 and acc_tag=1 is a trigger, and on the next cycle tag_clr is 1 with tag_clr_addr equal to the accessed block's aligned address.
- R6: With TAGGED=1, a hit whose acc_tag is 0 starts no prefetch and raises no tag_clr.
- R7: With TAGGED=1, one cycle after fill_valid=1, fill_tag_we is 1 and fill_tag_val equals fill_by_pf (0 for a demand fill, 1 for a prefetch fill); without fill_valid, fill_tag_we is 0.
- R8: While pf_valid=1 and pf_ready=0, pf_valid and pf_addr hold their values; a cycle with pf_valid=1 and pf_ready=1 completes the transfer.
- R9: A trigger in any cycle where pf_valid is already 1 is discarded, even when pf_ready is 1 in that cycle, so pf_valid is 0 on the cycle after a transfer.
- R10: A trigger whose target equals the most recently issued prefetch address (since reset) issues nothing.
- R11: A trigger that is not discarded makes pf_valid 1 with the new address on the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A demand access is presented this cycle |
| acc_addr | input | ADDR_W | Byte address of the demand access |
| acc_hit | input | 1 | The access hit in the cache |
| acc_tag | input | 1 | Tag bit of the line that was hit |
| fill_valid | input | 1 | The cache writes a line this cycle |
| fill_by_pf | input | 1 | That fill comes from a prefetch (1) or a demand fetch (0) |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_ready | input | 1 | The next level accepts the offered request |
| pf_addr | output | ADDR_W | Block-aligned address of the requested block |
| tag_clr | output | 1 | Clear the tag bit of the line at tag_clr_addr |
| tag_clr_addr | output | ADDR_W | Aligned address of the line whose tag is cleared |
| fill_tag_we | output | 1 | Write the tag bit of the line being filled |
| fill_tag_val | output | 1 | Tag value to store for that fill |

## Verification
Two things can fall in the same cycle: the downstream side accepting a pending request, and a fresh trigger (a miss, or a first hit on a prefetched line). Random stimulus drives pf_ready at about fifty percent against a small pool of blocks, so this overlap happens many times. A directed sequence also places a miss exactly on the cycle of acceptance. The check is that the trigger is discarded: pf_valid is 0 on the next cycle, while a tag clear requested in that same cycle still appears. The bench keeps its own model of pending and last-issued state and predicts every output from it.

// File: rtl/pf_pkg.sv
`timescale 1ns/1ps
package pf_pkg;

    typedef struct packed {
        logic we;
        logic val;
    } tagwr_t;

endpackage

// File: rtl/pf_trigger.sv
`timescale 1ns/1ps
module pf_trigger #(
    parameter bit TAGGED = 1'b1
) (
    input  logic acc_valid,
    input  logic acc_hit,
    input  logic acc_tag,
    output logic trig,
    output logic clr_req
);
    localparam logic TAG_EN = TAGGED;

    // First touch of a prefetched line (tag still set) in tagged mode
    logic first_use;

    always_comb begin
        first_use = acc_valid && acc_hit && acc_tag && TAG_EN;
        trig      = (acc_valid && !acc_hit) || first_use;
        clr_req   = first_use;
    end
endmodule

// File: rtl/pf_next_blk.sv
`timescale 1ns/1ps
module pf_next_blk #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] nxt
);
    localparam int OFF_W = $clog2(BLK_BYTES);

    generate
        if (OFF_W == 0) begin : g_byte_blk
            always_comb begin
                base = addr;
                nxt  = addr + ADDR_W'(1);
            end
        end else begin : g_wide_blk
            localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);
            localparam logic [ADDR_W-1:0] BLK_INC  = ADDR_W'(BLK_BYTES);
            always_comb begin
                base = addr & ~OFF_MASK;
                nxt  = base + BLK_INC;   // wraps modulo 2^ADDR_W
            end
        end
    endgenerate
endmodule

// File: rtl/pf_tagbook.sv
`timescale 1ns/1ps
module pf_tagbook
    import pf_pkg::*;
#(
    parameter bit TAGGED = 1'b1
) (
    input  logic   fill_valid,
    input  logic   fill_by_pf,
    output tagwr_t tw
);
    localparam logic TAG_EN = TAGGED;

    always_comb begin
        tw.we  = fill_valid && TAG_EN;
        tw.val = fill_by_pf && TAG_EN;
    end
endmodule

// File: rtl/seq_lookahead_pf.sv
`timescale 1ns/1ps
module seq_lookahead_pf
    import pf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter bit TAGGED    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_hit,
    input  logic              acc_tag,
    input  logic              fill_valid,
    input  logic              fill_by_pf,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr,
    output logic              tag_clr,
    output logic [ADDR_W-1:0] tag_clr_addr,
    output logic              fill_tag_we,
    output logic              fill_tag_val
);
    typedef struct packed {
        logic              pf_vld;
        logic [ADDR_W-1:0] pf_adr;
        logic              last_vld;
        logic [ADDR_W-1:0] last_adr;
        logic              clr;
        logic [ADDR_W-1:0] clr_adr;
        tagwr_t            tw;
    } state_t;

    state_t st_d, st_q;

    logic              trig;
    logic              clr_req;
    logic [ADDR_W-1:0] blk_base;
    logic [ADDR_W-1:0] blk_next;
    tagwr_t            tw_new;
    logic              dup_hit;
    logic              issue;

    pf_trigger #(.TAGGED(TAGGED)) u_trig (
        .acc_valid (acc_valid),
        .acc_hit   (acc_hit),
        .acc_tag   (acc_tag),
        .trig      (trig),
        .clr_req   (clr_req)
    );

    pf_next_blk #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_next (
        .addr (acc_addr),
        .base (blk_base),
        .nxt  (blk_next)
    );

    pf_tagbook #(.TAGGED(TAGGED)) u_tags (
        .fill_valid (fill_valid),
        .fill_by_pf (fill_by_pf),
        .tw         (tw_new)
    );

    always_comb begin
        st_d    = st_q;
        dup_hit = st_q.last_vld && (st_q.last_adr == blk_next);
        // Any trigger seen while the output slot is occupied is discarded
        issue   = trig && !st_q.pf_vld && !dup_hit;

        if (st_q.pf_vld && pf_ready) begin
            st_d.pf_vld = 1'b0;
        end
        if (issue) begin
            st_d.pf_vld   = 1'b1;
            st_d.pf_adr   = blk_next;
            st_d.last_vld = 1'b1;
            st_d.last_adr = blk_next;
        end

        st_d.clr = clr_req;
        if (clr_req) begin
            st_d.clr_adr = blk_base;
        end
        st_d.tw = tw_new;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pf_valid     = st_q.pf_vld;
    assign pf_addr      = st_q.pf_adr;
    assign tag_clr      = st_q.clr;
    assign tag_clr_addr = st_q.clr_adr;
    assign fill_tag_we  = st_q.tw.we;
    assign fill_tag_val = st_q.tw.val;
endmodule

// File: rtl/seq_lookahead_pf_chk.sv
`timescale 1ns/1ps
module seq_lookahead_pf_chk #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter bit TAGGED    = 1'b1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_hit,
    input logic              acc_tag,
    input logic              fill_valid,
    input logic              fill_by_pf,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr,
    input logic              tag_clr,
    input logic [ADDR_W-1:0] tag_clr_addr,
    input logic              fill_tag_we,
    input logic              fill_tag_val
);
    localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'(BLK_BYTES - 1);
    localparam logic              TAG_EN   = TAGGED;

    p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> ((pf_addr & OFF_MASK) == '0));

    p_pom_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!TAG_EN && acc_valid && acc_hit && !pf_valid) |=> !pf_valid);

    p_first_use_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (TAG_EN && acc_valid && acc_hit && acc_tag)
        |=> (tag_clr && tag_clr_addr == ($past(acc_addr) & ~OFF_MASK)));

    p_tag0_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (TAG_EN && acc_valid && acc_hit && !acc_tag && !pf_valid)
        |=> (!pf_valid && !tag_clr));

    p_fill_tag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (TAG_EN && fill_valid) |=> (fill_tag_we && fill_tag_val == $past(fill_by_pf)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

    p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready) |=> !pf_valid);
endmodule

bind seq_lookahead_pf seq_lookahead_pf_chk #(
    .ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .TAGGED(TAGGED)
) u_chk (.*);

// File: tb/seq_lookahead_pf_tb.sv
`timescale 1ns/1ps
module seq_lookahead_pf_tb;
    localparam int AW  = 32;
    localparam int BLK = 64;
    localparam logic [AW-1:0] MASK = AW'(BLK - 1);

    typedef struct {
        bit          v;
        bit [AW-1:0] a;
        bit          lv;
        bit [AW-1:0] last;
        bit          clr;
        bit [AW-1:0] clra;
        bit          we;
        bit          tv;
    } mdl_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 0, acc_hit = 0, acc_tag = 0, fill_valid = 0, fill_by_pf = 0, pf_ready = 0;
    logic [AW-1:0] acc_addr = '0;

    logic t_pv, t_clr, t_we, t_tv, p_pv, p_clr, p_we, p_tv;
    logic [AW-1:0] t_pa, t_ca, p_pa, p_ca;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    mdl_t mt, mp;

    always #5 clk = ~clk;

    seq_lookahead_pf #(.ADDR_W(AW), .BLK_BYTES(BLK), .TAGGED(1'b1)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .acc_tag(acc_tag), .fill_valid(fill_valid),
        .fill_by_pf(fill_by_pf), .pf_valid(t_pv), .pf_ready(pf_ready),
        .pf_addr(t_pa), .tag_clr(t_clr), .tag_clr_addr(t_ca),
        .fill_tag_we(t_we), .fill_tag_val(t_tv));

    seq_lookahead_pf #(.ADDR_W(AW), .BLK_BYTES(BLK), .TAGGED(1'b0)) u_pom (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_hit(acc_hit), .acc_tag(acc_tag), .fill_valid(fill_valid),
        .fill_by_pf(fill_by_pf), .pf_valid(p_pv), .pf_ready(pf_ready),
        .pf_addr(p_pa), .tag_clr(p_clr), .tag_clr_addr(p_ca),
        .fill_tag_we(p_we), .fill_tag_val(p_tv));

    // Expected next state, built from the requirements
    function automatic mdl_t mstep(mdl_t s, bit tg);
        mdl_t n = s;
        bit trig = acc_valid && (!acc_hit || (tg && acc_hit && acc_tag));   // R4 R5 R3 R6
        bit [AW-1:0] tgt = (acc_addr & ~MASK) + AW'(BLK);                   // R2
        if (s.v && pf_ready) n.v = 0;                                       // R8
        if (trig && !s.v && !(s.lv && s.last == tgt)) begin                 // R9 R10 R11
            n.v = 1; n.a = tgt; n.lv = 1; n.last = tgt;
        end
        n.clr = tg && acc_valid && acc_hit && acc_tag;                      // R5
        if (n.clr) n.clra = acc_addr & ~MASK;
        n.we = tg && fill_valid;                                            // R7
        n.tv = tg && fill_by_pf;
        return n;
    endfunction

    task automatic chk(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic compare(string req);
        chk({req, " tagged pf_valid"}, AW'(t_pv), AW'(mt.v));
        if (mt.v) chk({req, " R2 tagged pf_addr"}, t_pa, mt.a);
        chk({req, " R5 tagged tag_clr"}, AW'(t_clr), AW'(mt.clr));
        if (mt.clr) chk({req, " R5 tag_clr_addr"}, t_ca, mt.clra);
        chk({req, " R7 fill_tag_we"}, AW'(t_we), AW'(mt.we));
        if (mt.we) chk({req, " R7 fill_tag_val"}, AW'(t_tv), AW'(mt.tv));
        chk({req, " miss-only pf_valid"}, AW'(p_pv), AW'(mp.v));
        if (mp.v) chk({req, " R2 miss-only pf_addr"}, p_pa, mp.a);
        chk({req, " R3 miss-only tag outputs"}, AW'({p_clr, p_we}), AW'(0));
    endtask

    task automatic drive(bit av, logic [AW-1:0] ad, bit h, bit tg, bit fv, bit fp, bit rd);
        @(negedge clk);
        acc_valid = av; acc_addr = ad; acc_hit = h; acc_tag = tg;
        fill_valid = fv; fill_by_pf = fp; pf_ready = rd;
    endtask

    task automatic tick(string req);
        mdl_t nt = mstep(mt, 1'b1);
        mdl_t np = mstep(mp, 1'b0);
        @(posedge clk);
        #1;
        mt = nt; mp = np;
        compare(req);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        mt = '{default: 0};
        mp = '{default: 0};
        // R1: reset state, during and right after reset
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset pf_valid", AW'({t_pv, p_pv}), AW'(0));
        chk("R1 reset tag_clr", AW'({t_clr, p_clr}), AW'(0));
        chk("R1 reset fill_tag_we", AW'({t_we, p_we}), AW'(0));
        @(negedge clk);
        rst_n = 1;
        tick("R1 first cycle");

        // R4 R11: miss, request next cycle; held while not ready (R8)
        drive(1, 32'h0000_1010, 0, 0, 0, 0, 0); tick("R4 R11 miss");
        drive(0, '0, 0, 0, 0, 0, 0); tick("R8 hold");
        drive(0, '0, 0, 0, 0, 0, 0); tick("R8 hold");
        // R9: miss arriving on the accept cycle is discarded
        drive(1, 32'h0000_3000, 0, 0, 0, 0, 1); tick("R9 accept+trigger");
        chk("R9 pf_valid after accept", AW'(t_pv), AW'(0));
        // R10: same target as last issued is filtered
        drive(1, 32'h0000_1020, 0, 0, 0, 0, 1); tick("R10 duplicate");
        chk("R10 no duplicate", AW'(t_pv), AW'(0));
        // R5: first use of a prefetched line
        drive(1, 32'h0000_1044, 1, 1, 0, 0, 1); tick("R5 first use");
        chk("R5 tag_clr raised", AW'(t_clr), AW'(1));
        chk("R3 miss-only ignores tagged hit", AW'(p_pv), AW'(0));
        drive(0, '0, 0, 0, 0, 0, 1); tick("R5 accept");
        // R6: hit on tag 0 line
        drive(1, 32'h0000_5000, 1, 0, 0, 0, 1); tick("R6 tag0 hit");
        chk("R6 no prefetch", AW'(t_pv), AW'(0));
        // R7: demand and prefetch fills
        drive(0, '0, 0, 0, 1, 0, 1); tick("R7 demand fill");
        drive(0, '0, 0, 0, 1, 1, 1); tick("R7 prefetch fill");
        chk("R7 prefetch fill tag", AW'({t_we, t_tv}), AW'(3));
        // R2: wrap at top of address space
        drive(1, 32'hFFFF_FFC5, 0, 0, 0, 0, 0); tick("R2 wrap");
        chk("R2 wrap address", t_pa, '0);
        drive(0, '0, 0, 0, 0, 0, 1); tick("R8 accept");

        // Random mix over a small block pool
        void'($urandom(32'd1234));
        for (int i = 0; i < 4000; i++) begin
            logic [AW-1:0] ad = {22'($urandom_range(0, 1) ? 22'h3FFFFF : 22'h0),
                                 4'($urandom_range(0, 15)), 6'($urandom)};
            drive($urandom_range(0, 3) != 0, ad, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
            tick("R3 R4 R5 R6 R8 R9 R10 random");
        end
        finish_run();
    end
endmodule